// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block guards a processor against hangs. Software arms it through a single write-only control port that carries an arm bit and a 3-bit key. Once armed, the timer has to be serviced within a first window. If it is not serviced, the block raises a non-maskable interrupt request. The handler then has a second, shorter window to react. If that window also runs out, the block pulses a chip reset and falls back to the disarmed state.

Servicing is guarded by the key. A restart or disarm write only counts when its key field is the bitwise inverse of the key currently held. Any other key written while the timer runs replaces the stored key and leaves the countdown alone. A stray or runaway write therefore cannot keep the timer alive by chance. Both window lengths are parameters counted in clock cycles.

Top module: `guard_timer`

## Requirements
- R1: After reset the timer is disarmed, the stored key is 0, and both `nmiReq` and `chipRst` are low.
- R2: A write is taken on a clock edge where `wrEn` is high. It carries an arm bit on `wrArm` and a 3-bit key on `wrKey`.
- R3: While disarmed, a write with `wrArm`=0 has no effect. The timer stays disarmed and neither output rises.
- R4: While disarmed, a write with `wrArm`=1 arms the timer and stores `wrKey` as the current key.
- R5: While armed, including during the interrupt stage, a write with `wrArm`=0 and `wrKey` equal to the bitwise NOT of the current key disarms the timer. `nmiReq` is low from the next cycle.
- R6: While armed, a write with `wrArm`=1 and `wrKey` equal to the bitwise NOT of the current key restarts the first window and makes `wrKey` the new key. `nmiReq` is low from the next cycle.
- R7: While armed, a write whose key is not the inverse of the current key stores that key, whatever `wrArm` is, and does not restart or stop the countdown.
- R8: `nmiReq` rises FIRST_CYCLES clock edges after the edge that took the last arming or restart write. It then stays high until a restart, a disarm or the reset pulse.
- R9: If the timer is not serviced, `chipRst` is high for exactly one cycle, starting SECOND_CYCLES edges after `nmiReq` rose. In that same cycle `nmiReq` falls and the timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrArm | input | 1 | Arm bit of the written value |
| wrKey | input | 3 | Key field of the written value |
| nmiReq | output | 1 | Non-maskable interrupt request, level |
| chipRst | output | 1 | Chip reset request, one-cycle pulse |

## Verification
The only internal state is the phase, the cycle count and the stored key, and each one shows up at the outputs within one window length. A wrong stored key is caught at the next service write: a correct inverse is then refused and `nmiReq` rises on schedule. A write with a wrong key is caught when it is wrongly accepted and the interrupt is held back. An off-by-one count moves the `nmiReq` edge or the `chipRst` pulse by one cycle. The bench therefore checks both sides of each edge. A phase that fails to leave the disarmed or alert state shows up as a missing or extra pulse within SECOND_CYCLES cycles.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_ALERT = 2'd2
  } wdState_t;

  typedef struct packed {
    logic cntClr;
    logic keyLoad;
    logic fireRst;
  } wdStrobe_t;

endpackage

// File: rtl/guard_timer_dp.sv
module guard_timer_dp
  import guard_timer_pkg::*;
#(
  parameter int FIRST_CYCLES  = 5000000,
  parameter int SECOND_CYCLES = 165000,
  parameter int KEY_W         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [KEY_W-1:0] wrKey,
  output logic             keyMatch,
  output logic             firstDone,
  output logic             secondDone,
  output logic             chipRst
);

  localparam int MAX_CYC = (FIRST_CYCLES > SECOND_CYCLES) ? FIRST_CYCLES : SECOND_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FIRST_LAST  = CNT_W'(FIRST_CYCLES - 1);
  localparam logic [CNT_W-1:0] SECOND_LAST = CNT_W'(SECOND_CYCLES - 1);

  logic [CNT_W-1:0] count;
  logic [KEY_W-1:0] keyReg;
  logic             rstPulse;

  // elapsed-cycle counter, cleared by control on every phase change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strobe.cntClr) count <= '0;
    else                    count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               keyReg <= '0;
    else if (strobe.keyLoad) keyReg <= wrKey;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPulse <= 1'b0;
    else       rstPulse <= strobe.fireRst;
  end

  assign keyMatch   = (wrKey == ~keyReg);
  assign firstDone  = (count == FIRST_LAST);
  assign secondDone = (count == SECOND_LAST);
  assign chipRst    = rstPulse;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    chipRst |=> !chipRst); // R9

  AST_KEY_STORED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keyLoad |=> (keyMatch == ($past(wrKey) == ~wrKey))); // R7

endmodule

// File: rtl/guard_timer_ctrl.sv
module guard_timer_ctrl
  import guard_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrArm,
  input  logic      keyMatch,
  input  logic      firstDone,
  input  logic      secondDone,
  output wdStrobe_t strobe,
  output logic      nmiReq
);

  wdState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (state == ST_OFF) begin
      strobe.cntClr = 1'b1;
      if (wrEn && wrArm) begin
        strobe.keyLoad = 1'b1;
        stateNext      = ST_RUN;
      end
    end else if (wrEn && keyMatch) begin
      // valid service: restart or disarm, takes priority over expiry
      strobe.keyLoad = 1'b1;
      strobe.cntClr  = 1'b1;
      stateNext      = wrArm ? ST_RUN : ST_OFF;
    end else begin
      if (wrEn) strobe.keyLoad = 1'b1;
      if (state == ST_RUN && firstDone) begin
        strobe.cntClr = 1'b1;
        stateNext     = ST_ALERT;
      end else if (state == ST_ALERT && secondDone) begin
        strobe.cntClr  = 1'b1;
        strobe.fireRst = 1'b1;
        stateNext      = ST_OFF;
      end
    end
  end

  assign nmiReq = (state == ST_ALERT);

  AST_OFF_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && wrEn && !wrArm) |=> (state == ST_OFF)); // R3

  AST_ARM_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && wrEn && wrArm) |=> (state == ST_RUN)); // R4

  AST_SERVICE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_OFF && wrEn && !wrArm && keyMatch) |=> !nmiReq); // R5

  AST_SERVICE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_OFF && wrEn && wrArm && keyMatch) |=> (state == ST_RUN)); // R6

  AST_ALERT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiReq) |-> ($past(state) == ST_RUN && $past(firstDone))); // R8

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int FIRST_CYCLES  = 5000000,
  parameter int SECOND_CYCLES = 165000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrArm,
  input  logic [2:0] wrKey,
  output logic       nmiReq,
  output logic       chipRst
);

  localparam int KEY_W = 3;

  wdStrobe_t strobe;
  logic      keyMatch;
  logic      firstDone;
  logic      secondDone;

  guard_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrArm      (wrArm),
    .keyMatch   (keyMatch),
    .firstDone  (firstDone),
    .secondDone (secondDone),
    .strobe     (strobe),
    .nmiReq     (nmiReq)
  );

  guard_timer_dp #(
    .FIRST_CYCLES  (FIRST_CYCLES),
    .SECOND_CYCLES (SECOND_CYCLES),
    .KEY_W         (KEY_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrKey      (wrKey),
    .keyMatch   (keyMatch),
    .firstDone  (firstDone),
    .secondDone (secondDone),
    .chipRst    (chipRst)
  );

  AST_NMI_DROPS_AT_RST: assert property (@(posedge clk) disable iff (!rstN)
    chipRst |-> !nmiReq); // R9

endmodule

// File: tb/sim_guard_timer.sv
module sim_guard_timer;

  localparam int FIRST  = 20;
  localparam int SECOND = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrArm = 1'b0;
  logic [2:0] wrKey = 3'd0;
  logic       nmiReq;
  logic       chipRst;

  guard_timer #(.FIRST_CYCLES(FIRST), .SECOND_CYCLES(SECOND)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrArm(wrArm), .wrKey(wrKey),
    .nmiReq(nmiReq), .chipRst(chipRst)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    cyc;
    logic  expNmi;
    logic  expRst;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare scheduled expectations away from the active edge
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].cyc <= cyc) begin
      expItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (it.cyc < cyc) begin
        fails++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", it.tag, it.cyc, cyc);
      end else if (nmiReq !== it.expNmi || chipRst !== it.expRst) begin
        fails++;
        $display("FAIL %s @%0d: nmiReq=%b chipRst=%b, expected nmiReq=%b chipRst=%b",
                 it.tag, cyc, nmiReq, chipRst, it.expNmi, it.expRst);
      end
    end
  end

  task automatic expectAt(input int c, input logic n, input logic r, input string tag);
    expItem_t it;
    it.cyc = c; it.expNmi = n; it.expRst = r; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // driver: called at a falling edge; returns the number of the edge that takes the write
  task automatic wr(input logic arm, input logic [2:0] key, output int edgeNo);
    edgeNo = cyc + 1;
    wrEn = 1'b1; wrArm = arm; wrKey = key;
    @(negedge clk);
    wrEn = 1'b0; wrArm = 1'b0; wrKey = 3'd0;
  endtask

  task automatic waitTo(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, m, p, q, r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    expectAt(cyc + 1, 1'b0, 1'b0, "R1 reset state");
    expectAt(cyc + 2, 1'b0, 1'b0, "R1 reset state");
    waitTo(cyc + 3);

    // R3: disarm write while disarmed has no effect
    wr(1'b0, 3'd5, n);
    expectAt(n + FIRST, 1'b0, 1'b0, "R3 no arm on disarm write");
    expectAt(n + FIRST + SECOND, 1'b0, 1'b0, "R3 no reset on disarm write");
    waitTo(n + FIRST + SECOND + 2);

    // R4 R8 R9 R2: arm and let both windows expire
    wr(1'b1, 3'd3, n);
    expectAt(n + FIRST - 1, 1'b0, 1'b0, "R8 nmi not before window");
    expectAt(n + FIRST, 1'b1, 1'b0, "R4 R8 nmi rises");
    expectAt(n + FIRST + SECOND - 1, 1'b1, 1'b0, "R8 nmi held, R9 no early reset");
    expectAt(n + FIRST + SECOND, 1'b0, 1'b1, "R9 reset pulse");
    expectAt(n + FIRST + SECOND + 1, 1'b0, 1'b0, "R9 single-cycle pulse");
    expectAt(n + 2 * FIRST + SECOND + 2, 1'b0, 1'b0, "R9 disarmed after pulse");
    waitTo(n + 2 * FIRST + SECOND + 3);

    // R6 R4: restart with inverse key moves the window, key becomes 4
    wr(1'b1, 3'd3, n);
    waitTo(n + 9);
    wr(1'b1, 3'd4, m);
    expectAt(n + FIRST, 1'b0, 1'b0, "R6 restart delays nmi");
    expectAt(m + FIRST - 1, 1'b0, 1'b0, "R6 nmi not before new window");
    expectAt(m + FIRST, 1'b1, 1'b0, "R6 nmi after new window");
    waitTo(m + FIRST + 1);
    // R5: disarm during interrupt stage with ~4 = 3
    wr(1'b0, 3'd3, p);
    expectAt(p, 1'b0, 1'b0, "R5 stop drops nmi");
    expectAt(m + FIRST + SECOND, 1'b0, 1'b0, "R5 no reset after stop");
    expectAt(p + FIRST + SECOND + 2, 1'b0, 1'b0, "R5 stays disarmed");
    waitTo(p + FIRST + SECOND + 3);

    // R7: wrong key changes key, does not restart
    wr(1'b1, 3'd1, n);
    waitTo(n + 2);
    wr(1'b1, 3'd2, m);            // ~1 would be 6; key becomes 2
    waitTo(n + 4);
    wr(1'b0, 3'd0, q);            // not ~2: key change, no stop; key becomes 0
    expectAt(n + FIRST, 1'b1, 1'b0, "R7 key change does not restart or stop");
    waitTo(n + FIRST + 1);
    wr(1'b1, 3'd6, p);            // ~0 = 7, so 6 is a key change; key becomes 6
    expectAt(p, 1'b1, 1'b0, "R7 stale inverse refused");
    waitTo(p + 1);
    wr(1'b1, 3'd1, r);            // ~6 = 1: valid restart
    expectAt(r, 1'b0, 1'b0, "R6 R7 restart with inverse of changed key");
    expectAt(r + FIRST - 1, 1'b0, 1'b0, "R6 window restarted");
    expectAt(r + FIRST, 1'b1, 1'b0, "R8 nmi after restarted window");
    waitTo(r + FIRST + 1);
    wr(1'b0, 3'd6, q);            // ~1 = 6: stop
    expectAt(q, 1'b0, 1'b0, "R5 stop with inverse key");
    expectAt(r + FIRST + SECOND, 1'b0, 1'b0, "R5 no reset after stop");
    waitTo(r + FIRST + SECOND + 2);

    while (sbQ.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule